// File: doc/BRIEF.md
# Dual-Channel Serial Converter Input Front End

This block receives converter codes over a three-wire serial port and presents them on two parallel holding registers, one for each output channel. While the active-low select is low, each rising edge of the serial clock shifts one bit into a WIDTH-bit shift register, most significant bit first. A frame may carry more bits than WIDTH; the earliest bits fall off the top and only the last WIDTH bits received remain.

Two active-low load controls open level-sensitive paths from the shift register into holding register A and holding register B. While a load control is low, its holding register tracks the shift register. While it is high, the holding register keeps its value. Pulsing both controls together copies one word into both channels. The host must raise a load control again before it shifts in the next frame.

An asynchronous active-low reset forces both holding registers to a start value and takes priority over any open load path. A static strap input selects the start value: all zeros, or midscale, which has only the top bit set. The reset does not touch the shift register.

Top module: `sdac_dual_front`

## Requirements
- R1: With `ser_sel_n` low, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the shift register, and the older bits move up by one. After exactly WIDTH edges followed by a load pulse, the holding register equals the frame, whose first transmitted bit lands in bit WIDTH-1.
- R2: While `ser_sel_n` is high, rising edges of `ser_clk` leave the shift register unchanged.
- R3: For a frame longer than WIDTH bits (for example 16), only the last WIDTH bits received are kept.
- R4: A low pulse on `load_a_n` alone copies the shift register into `chan_a` and leaves `chan_b` unchanged.
- R5: A low pulse on `load_b_n` alone copies the shift register into `chan_b` and leaves `chan_a` unchanged.
- R6: Pulsing `load_a_n` and `load_b_n` low together puts the same word into both outputs.
- R7: While a load control is low, its output follows the shift register after every shifted bit.
- R8: While a load control is high, shifting a new frame does not change its output.
- R9: With `arst_n` low and `mid_strap` low, both outputs are all zeros, without waiting for any clock.
- R10: With `arst_n` low and `mid_strap` high, both outputs are midscale: bit WIDTH-1 is 1 and every other bit is 0.
- R11: While `arst_n` is low, the outputs hold the reset value even when the load controls are low and data is shifting.
- R12: The reset leaves the shift register unchanged. A word shifted in during reset is loaded by a load pulse after the reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial clock. Shifting happens on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_sel_n | input | 1 | Active-low select that enables shifting |
| load_a_n | input | 1 | Active-low, level-sensitive load into channel A |
| load_b_n | input | 1 | Active-low, level-sensitive load into channel B |
| arst_n | input | 1 | Asynchronous active-low reset of both holding registers |
| mid_strap | input | 1 | Reset value select: 0 gives zero, 1 gives midscale |
| chan_a | output | WIDTH | Holding register A |
| chan_b | output | WIDTH | Holding register B |

## Verification
The shift register has no direct output, so a wrong bit order, a missed edge or a shift while deselected stays hidden until a load control opens. It then shows on the output at once, and a transparent load exposes it on the same shifted bit. A holding register that is wrongly open or wrongly latched shows up as an output that moves when the bench shifts data with the loads high, or that stays still when a load is low. A wrong reset value or a missing reset priority shows on both outputs while the reset is still low. A 12-bit build and a 10-bit build run on the same stimulus, so the truncation of long frames is checked at two widths.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;

  typedef enum logic {
    RSTV_ZERO = 1'b0,
    RSTV_MID  = 1'b1
  } rst_kind_e;
endpackage

// File: rtl/sdac_shift_in.sv
module sdac_shift_in #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_sel_n,
  input  logic             arst_n,
  output logic [WIDTH-1:0] shift_word
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;
  logic             sr_en;

  always_comb begin
    sr_en = ~ser_sel_n;
    sr_d  = {sr_q[WIDTH-2:0], ser_data};
  end

  always_ff @(posedge ser_clk) begin
    if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign shift_word = sr_q;

  // R2
  sr_hold_chk: assert property (@(posedge ser_clk) disable iff (!arst_n)
    ser_sel_n |=> $stable(shift_word));

  // R1
  sr_shift_chk: assert property (@(posedge ser_clk) disable iff (!arst_n)
    !ser_sel_n |=> (shift_word[0] == $past(ser_data)) &&
                   (shift_word[WIDTH-1:1] == $past(shift_word[WIDTH-2:0])));
endmodule

// File: rtl/sdac_reset_value.sv
module sdac_reset_value #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             mid_strap,
  output logic [WIDTH-1:0] init_word
);
  import sdac_pkg::*;
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  rst_kind_e kind;

  always_comb begin
    kind = rst_kind_e'(mid_strap);
    unique case (kind)
      RSTV_MID:  init_word = MID_CODE;
      default:   init_word = '0;
    endcase
  end
endmodule

// File: rtl/sdac_hold_latch.sv
module sdac_hold_latch #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             arst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] init_word,
  input  logic [WIDTH-1:0] shift_word,
  output logic [WIDTH-1:0] hold_word
);
  logic open_en;

  assign open_en = ~load_n;

  always_latch begin
    if (!arst_n) begin
      hold_word <= init_word;
    end else if (open_en) begin
      hold_word <= shift_word;
    end
  end
endmodule

// File: rtl/sdac_dual_front.sv
module sdac_dual_front #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_sel_n,
  input  logic             load_a_n,
  input  logic             load_b_n,
  input  logic             arst_n,
  input  logic             mid_strap,
  output logic [WIDTH-1:0] chan_a,
  output logic [WIDTH-1:0] chan_b
);
  import sdac_pkg::*;

  logic [WIDTH-1:0] shift_word;
  logic [WIDTH-1:0] init_word;
  logic             load_n [NUM_CH];
  logic [WIDTH-1:0] hold   [NUM_CH];

  assign load_n[CH_A] = load_a_n;
  assign load_n[CH_B] = load_b_n;

  sdac_shift_in #(.WIDTH(WIDTH)) u_shift (
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_sel_n (ser_sel_n),
    .arst_n    (arst_n),
    .shift_word(shift_word)
  );

  sdac_reset_value #(.WIDTH(WIDTH)) u_rstv (
    .mid_strap(mid_strap),
    .init_word(init_word)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sdac_hold_latch #(.WIDTH(WIDTH)) u_hold (
      .arst_n    (arst_n),
      .load_n    (load_n[c]),
      .init_word (init_word),
      .shift_word(shift_word),
      .hold_word (hold[c])
    );
  end

  assign chan_a = hold[CH_A];
  assign chan_b = hold[CH_B];

  // R7
  follow_a_chk: assert property (@(posedge ser_clk) disable iff (!arst_n)
    !load_a_n |-> chan_a == shift_word);

  // R7
  follow_b_chk: assert property (@(posedge ser_clk) disable iff (!arst_n)
    !load_b_n |-> chan_b == shift_word);

  // R11 (R9, R10: reset value on both channels while reset is low)
  always @(negedge ser_clk) begin
    if (!arst_n) begin
      rst_val_chk: assert (chan_a == init_word && chan_b == init_word);
    end
  end
endmodule

// File: tb/sim_sdac_dual_front.sv
module sim_sdac_dual_front;
  logic clk = 1'b0;
  logic sck_en = 1'b0;
  logic ser_clk;
  logic ser_data = 1'b0;
  logic ser_sel_n = 1'b1;
  logic load_a_n = 1'b1;
  logic load_b_n = 1'b1;
  logic arst_n = 1'b0;
  logic mid_strap = 1'b0;
  logic [11:0] a12, b12;
  logic [9:0]  a10, b10;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  assign ser_clk = clk & sck_en;

  sdac_dual_front #(.WIDTH(12)) u0 (
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_sel_n(ser_sel_n),
    .load_a_n(load_a_n), .load_b_n(load_b_n), .arst_n(arst_n),
    .mid_strap(mid_strap), .chan_a(a12), .chan_b(b12));

  sdac_dual_front #(.WIDTH(10)) u1 (
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_sel_n(ser_sel_n),
    .load_a_n(load_a_n), .load_b_n(load_b_n), .arst_n(arst_n),
    .mid_strap(mid_strap), .chan_a(a10), .chan_b(b10));

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input logic [15:0] ea, input logic [15:0] eb, input string tag);
    chk({4'h0, a12}, {4'h0, ea[11:0]}, {tag, " w12 A"});
    chk({4'h0, b12}, {4'h0, eb[11:0]}, {tag, " w12 B"});
    chk({6'h0, a10}, {6'h0, ea[9:0]},  {tag, " w10 A"});
    chk({6'h0, b10}, {6'h0, eb[9:0]},  {tag, " w10 B"});
  endtask

  task automatic send(input logic [15:0] bits, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ser_sel_n = 1'b0;
      ser_data  = bits[len-1-i];
      sck_en    = 1'b1;
    end
    @(negedge clk);
    sck_en    = 1'b0;
    ser_sel_n = 1'b1;
  endtask

  task automatic pulse(input logic la, input logic lb);
    @(negedge clk);
    load_a_n = ~la;
    load_b_n = ~lb;
    @(negedge clk);
    load_a_n = 1'b1;
    load_b_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_zero();
    @(negedge clk);
    chk_all(16'h0000, 16'h0000, "R9 reset zero");
    arst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_load_a();
    send(16'h0A5C, 12);
    pulse(1'b1, 1'b0);
    chk_all(16'h0A5C, 16'h0000, "R1 R4 load A only");
  endtask

  task automatic t_load_b();
    send(16'h0F31, 12);
    pulse(1'b0, 1'b1);
    chk_all(16'h0A5C, 16'h0F31, "R5 load B only");
  endtask

  task automatic t_both();
    send(16'h0C93, 12);
    pulse(1'b1, 1'b1);
    chk_all(16'h0C93, 16'h0C93, "R6 load both");
  endtask

  task automatic t_long_frame();
    send(16'hB6E7, 16);
    pulse(1'b1, 1'b1);
    chk_all(16'hB6E7, 16'hB6E7, "R3 16-bit frame");
  endtask

  task automatic t_select_high();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ser_sel_n = 1'b1;
      ser_data  = ~ser_data;
      sck_en    = 1'b1;
    end
    @(negedge clk);
    sck_en = 1'b0;
    pulse(1'b1, 1'b0);
    chk_all(16'hB6E7, 16'hB6E7, "R2 clocks ignored while deselected");
  endtask

  task automatic t_opaque();
    send(16'h0123, 12);
    @(negedge clk);
    chk_all(16'hB6E7, 16'hB6E7, "R8 outputs hold while shifting");
  endtask

  task automatic t_transparent();
    logic [15:0] model;
    logic [3:0]  nb;
    model = 16'h0123;
    nb    = 4'b1011;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      load_a_n  = 1'b0;
      ser_sel_n = 1'b0;
      ser_data  = nb[3-i];
      sck_en    = 1'b1;
      @(negedge clk);
      sck_en    = 1'b0;
      model     = {model[14:0], nb[3-i]};
      chk_all(model, 16'hB6E7, "R7 transparent follow");
    end
    @(negedge clk);
    load_a_n  = 1'b1;
    ser_sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_midscale_override();
    @(negedge clk);
    mid_strap = 1'b1;
    arst_n    = 1'b0;
    @(negedge clk);
    chk({4'h0, a12}, 16'h0800, "R10 midscale w12 A");
    chk({4'h0, b12}, 16'h0800, "R10 midscale w12 B");
    chk({6'h0, a10}, 16'h0200, "R10 midscale w10 A");
    chk({6'h0, b10}, 16'h0200, "R10 midscale w10 B");
    load_a_n = 1'b0;
    load_b_n = 1'b0;
    send(16'h0DAB, 12);
    chk({4'h0, a12}, 16'h0800, "R11 reset over load w12 A");
    chk({4'h0, b12}, 16'h0800, "R11 reset over load w12 B");
    chk({6'h0, a10}, 16'h0200, "R11 reset over load w10 A");
    load_a_n = 1'b1;
    load_b_n = 1'b1;
    @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);
    chk({4'h0, a12}, 16'h0800, "R11 closed after release w12 A");
    pulse(1'b1, 1'b0);
    chk({4'h0, a12}, 16'h0DAB, "R12 shift kept through reset w12 A");
    chk({6'h0, a10}, 16'h01AB, "R12 shift kept through reset w10 A");
    chk({4'h0, b12}, 16'h0800, "R12 B still midscale w12");
  endtask

  initial begin
    t_reset_zero();
    t_load_a();
    t_load_b();
    t_both();
    t_long_frame();
    t_select_high();
    t_opaque();
    t_transparent();
    t_midscale_override();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule